// File: doc/BRIEF.md
# Memory-Mapped Test Block Generator

A stimulus source for streaming datapaths. Software fills a waveform buffer with packed complex samples and programs a small bank of write-only control registers. Once enabled, the generator reads the buffer in a loop over a programmable address window and emits the samples as fixed-length blocks. Each block is framed with start and end markers, and a programmable number of idle cycles follows each block. The first beat of every Nth block carries a sync mark, and every block carries a 64-bit block sequence number that counts up from a programmed start value.

The output is a valid/ready stream. A beat transfers on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the generator holds every output stable and does not advance. The source never withdraws a beat it has offered. Idle gap cycles are counted only on cycles where the output is free to move, so back-pressure stretches a gap but never shortens it. Playback position, block position and sync phase all carry over from one block to the next. When enable is cleared, the block in flight still runs to its end marker.

Top module: `bg_stream_gen`

## Requirements
- R1: After reset, `out_valid`, `out_sop`, `out_eop` and `out_sync` are low, all control registers are zero, and generation is disabled.
- R2: A write with `reg_wr` high goes to the register at `reg_addr`. Offset 0 bit 0 is enable. Offset 1 is the block length in samples. Offset 2 is the blocks-per-sync count. Offset 3 is the gap length in cycles. Offset 4 is the first window address and offset 5 is the last. Offsets 6 and 7 hold bits 31:0 and 63:32 of the initial sequence number. A block length of 0 acts as 1, and a blocks-per-sync count of 0 acts as 1.
- R3: A write with `buf_wr` high stores `buf_wdata` at `buf_addr`. Bits 2*DAT_W-1:DAT_W are the imaginary part and bits DAT_W-1:0 are the real part, and they appear on `out_im` and `out_re` when that address is played.
- R4: Each block is exactly block-length accepted beats. `out_sop` is high only on its first beat and `out_eop` only on its last. `out_valid` never drops inside a block.
- R5: With `out_ready` held high, exactly gap-length cycles with `out_valid` low separate an end-of-block beat from the next start-of-block beat. A gap of 0 gives back-to-back blocks.
- R6: Blocks are numbered from 0 at each start of generation. `out_sync` is high, together with `out_sop`, on the first beat of each block whose number is a multiple of blocks-per-sync, and low on every other beat.
- R7: `out_bsn` equals the initial sequence number for block 0 after a start and increases by exactly 1 per block, carrying across all 64 bits. It is constant across the beats of a block.
- R8: While `out_valid` is high and `out_ready` is low, all outputs keep their values on the next cycle. No beat is lost or repeated.
- R9: Clearing enable mid-block completes the current block, ending with `out_eop`. After that, `out_valid` stays low until enable is set again.
- R10: Playback starts at the first window address on each start of generation. It steps by one address per accepted beat, wraps from the last window address to the first, and carries on across block boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_addr | input | 3 | Control register offset |
| reg_wdata | input | REG_W | Control register write data |
| buf_wr | input | 1 | Waveform buffer write strobe |
| buf_addr | input | ADDR_W | Waveform buffer write address |
| buf_wdata | input | 2*DAT_W | Packed complex sample {im, re} |
| out_ready | input | 1 | Downstream ready |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat of a block |
| out_eop | output | 1 | Last beat of a block |
| out_sync | output | 1 | Sync mark on selected block starts |
| out_re | output | DAT_W | Real part of the sample |
| out_im | output | DAT_W | Imaginary part of the sample |
| out_bsn | output | 2*REG_W | Block sequence number |

## Verification
The bench builds the generator with a 64-entry buffer (ADDR_W=6), 16-bit components and 16-bit counts. With this buffer size, windows can sit against the top address, collapse to a single entry, or be shorter or longer than a block, so wrap and carry-over cases are short to reach. An initial sequence number just below a 32-bit boundary exercises the carry into the upper half. Directed runs with `out_ready` held high measure exact gap lengths and cover zero-valued length and sync settings. Seeded random runs with random back-pressure check the hold behaviour, beat accounting and the mid-block stop.

// File: rtl/bg_pkg.sv
package bg_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_ENABLE   = 3'd0;
  localparam logic [REG_AW-1:0] REG_BLK_LEN  = 3'd1;
  localparam logic [REG_AW-1:0] REG_BLK_SYNC = 3'd2;
  localparam logic [REG_AW-1:0] REG_GAP_LEN  = 3'd3;
  localparam logic [REG_AW-1:0] REG_WIN_LO   = 3'd4;
  localparam logic [REG_AW-1:0] REG_WIN_HI   = 3'd5;
  localparam logic [REG_AW-1:0] REG_SEQ_LO   = 3'd6;
  localparam logic [REG_AW-1:0] REG_SEQ_HI   = 3'd7;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bg_ctrl_regs.sv
module bg_ctrl_regs
  import bg_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [REG_AW-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  output logic                 enable,
  output logic [CNT_W-1:0]     blk_len,
  output logic [CNT_W-1:0]     blk_per_sync,
  output logic [CNT_W-1:0]     gap_len,
  output logic [ADDR_W-1:0]    win_first,
  output logic [ADDR_W-1:0]    win_last,
  output logic [2*REG_W-1:0]   seq_init
);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable       <= 1'b0;
      blk_len      <= '0;
      blk_per_sync <= '0;
      gap_len      <= '0;
      win_first    <= '0;
      win_last     <= '0;
      seq_init     <= '0;
    end else if (wr) begin
      case (addr)
        REG_ENABLE:   enable       <= wdata[0];
        REG_BLK_LEN:  blk_len      <= wdata[CNT_W-1:0];
        REG_BLK_SYNC: blk_per_sync <= wdata[CNT_W-1:0];
        REG_GAP_LEN:  gap_len      <= wdata[CNT_W-1:0];
        REG_WIN_LO:   win_first    <= wdata[ADDR_W-1:0];
        REG_WIN_HI:   win_last     <= wdata[ADDR_W-1:0];
        REG_SEQ_LO:   seq_init[REG_W-1:0]       <= wdata;
        REG_SEQ_HI:   seq_init[2*REG_W-1:REG_W] <= wdata;
        default: ;
      endcase
    end
  end

  // R2: an enable write lands on the next cycle
  assert_enable_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == REG_ENABLE) |=> (enable == $past(wdata[0])));

  // R2: a block length write lands on the next cycle
  assert_len_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == REG_BLK_LEN) |=> (blk_len == $past(wdata[CNT_W-1:0])));

endmodule

// File: rtl/bg_wave_buf.sv
module bg_wave_buf #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/bg_block_seq.sv
module bg_block_seq
  import bg_pkg::*;
#(
  parameter int DAT_W  = 16,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16,
  parameter int BSN_W  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [CNT_W-1:0]   blk_len,
  input  logic [CNT_W-1:0]   blk_per_sync,
  input  logic [CNT_W-1:0]   gap_len,
  input  logic [ADDR_W-1:0]  win_first,
  input  logic [ADDR_W-1:0]  win_last,
  input  logic [BSN_W-1:0]   seq_init,
  input  logic [2*DAT_W-1:0] rd_data,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic               out_sync,
  output logic [DAT_W-1:0]   out_re,
  output logic [DAT_W-1:0]   out_im,
  output logic [BSN_W-1:0]   out_bsn
);

  seq_state_e        state;
  logic [CNT_W-1:0]  smp_cnt;
  logic [CNT_W-1:0]  sync_cnt;
  logic [CNT_W-1:0]  gap_cnt;
  logic [BSN_W-1:0]  bsn_next;

  logic              advance;
  logic [CNT_W-1:0]  len_eff;
  logic [CNT_W-1:0]  sync_eff;
  logic              first_smp;
  logic              last_smp;
  logic [ADDR_W-1:0] addr_step;

  always_comb begin
    advance   = !out_valid || out_ready;
    len_eff   = (blk_len == '0) ? CNT_W'(1) : blk_len;
    sync_eff  = (blk_per_sync == '0) ? CNT_W'(1) : blk_per_sync;
    first_smp = (smp_cnt == '0);
    last_smp  = (smp_cnt == len_eff - CNT_W'(1));
    addr_step = (rd_addr == win_last) ? win_first : rd_addr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      smp_cnt   <= '0;
      sync_cnt  <= '0;
      gap_cnt   <= '0;
      bsn_next  <= '0;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_sync  <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_bsn   <= '0;
    end else if (advance) begin
      case (state)
        SEQ_IDLE: begin
          out_valid <= 1'b0;
          out_sop   <= 1'b0;
          out_eop   <= 1'b0;
          out_sync  <= 1'b0;
          if (enable) begin
            rd_addr  <= win_first;
            smp_cnt  <= '0;
            sync_cnt <= '0;
            bsn_next <= seq_init;
            state    <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          out_valid <= 1'b1;
          out_re    <= rd_data[DAT_W-1:0];
          out_im    <= rd_data[2*DAT_W-1:DAT_W];
          out_sop   <= first_smp;
          out_eop   <= last_smp;
          out_sync  <= first_smp && (sync_cnt == '0);
          rd_addr   <= addr_step;
          if (first_smp) begin
            out_bsn  <= bsn_next;
            bsn_next <= bsn_next + BSN_W'(1);
            sync_cnt <= (sync_cnt >= sync_eff - CNT_W'(1)) ? '0 : sync_cnt + CNT_W'(1);
          end
          if (last_smp) begin
            smp_cnt <= '0;
            if (gap_len != '0) begin
              gap_cnt <= '0;
              state   <= SEQ_GAP;
            end else begin
              state <= enable ? SEQ_RUN : SEQ_IDLE;
            end
          end else begin
            smp_cnt <= smp_cnt + CNT_W'(1);
          end
        end
        SEQ_GAP: begin
          out_valid <= 1'b0;
          out_sop   <= 1'b0;
          out_eop   <= 1'b0;
          out_sync  <= 1'b0;
          gap_cnt   <= gap_cnt + CNT_W'(1);
          if (gap_cnt + CNT_W'(1) >= gap_len) begin
            state <= enable ? SEQ_RUN : SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Tracking for the sequence-number step check
  logic             chk_have_prev;
  logic [BSN_W-1:0] chk_prev_bsn;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_have_prev <= 1'b0;
      chk_prev_bsn  <= '0;
    end else if (state == SEQ_IDLE && !out_valid) begin
      chk_have_prev <= 1'b0;
    end else if (out_valid && out_ready && out_sop) begin
      chk_have_prev <= 1'b1;
      chk_prev_bsn  <= out_bsn;
    end
  end

  // R8: an offered beat that is not taken stays put
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) &&
      $stable(out_sop) && $stable(out_eop) && $stable(out_sync) && $stable(out_bsn)));

  // R4: markers only on valid beats
  assert_marks_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (out_sop || out_eop) |-> out_valid);

  // R4: a block has no holes
  assert_no_bubble_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_eop) |=> out_valid);

  // R4: valid rises only at a block start
  assert_block_start_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid)) |-> out_sop);

  // R6: sync marks only block starts
  assert_sync_on_sop_R6: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> (out_sop && out_valid));

  // R7: consecutive blocks differ by one in sequence number
  assert_bsn_step_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sop && chk_have_prev && !(out_ready && $past(out_valid && !out_ready)))
      |-> (out_bsn == chk_prev_bsn + BSN_W'(1)));

  // R9: disabled and idle stays quiet
  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!enable && state == SEQ_IDLE && !out_valid) |=> !out_valid);

endmodule

// File: rtl/bg_stream_gen.sv
module bg_stream_gen
  import bg_pkg::*;
#(
  parameter int DAT_W  = 16,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 buf_wr,
  input  logic [ADDR_W-1:0]    buf_addr,
  input  logic [2*DAT_W-1:0]   buf_wdata,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic                 out_sync,
  output logic [DAT_W-1:0]     out_re,
  output logic [DAT_W-1:0]     out_im,
  output logic [2*REG_W-1:0]   out_bsn
);

  localparam int WORD_W = 2 * DAT_W;
  localparam int BSN_W  = 2 * REG_W;

  logic              enable;
  logic [CNT_W-1:0]  blk_len;
  logic [CNT_W-1:0]  blk_per_sync;
  logic [CNT_W-1:0]  gap_len;
  logic [ADDR_W-1:0] win_first;
  logic [ADDR_W-1:0] win_last;
  logic [BSN_W-1:0]  seq_init;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;

  bg_ctrl_regs #(
    .REG_W (REG_W),
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .enable      (enable),
    .blk_len     (blk_len),
    .blk_per_sync(blk_per_sync),
    .gap_len     (gap_len),
    .win_first   (win_first),
    .win_last    (win_last),
    .seq_init    (seq_init)
  );

  bg_wave_buf #(
    .WORD_W(WORD_W),
    .ADDR_W(ADDR_W)
  ) u_buf (
    .clk    (clk),
    .wr_en  (buf_wr),
    .wr_addr(buf_addr),
    .wr_data(buf_wdata),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  bg_block_seq #(
    .DAT_W (DAT_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .BSN_W (BSN_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .blk_len     (blk_len),
    .blk_per_sync(blk_per_sync),
    .gap_len     (gap_len),
    .win_first   (win_first),
    .win_last    (win_last),
    .seq_init    (seq_init),
    .rd_data     (rd_data),
    .rd_addr     (rd_addr),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_sync    (out_sync),
    .out_re      (out_re),
    .out_im      (out_im),
    .out_bsn     (out_bsn)
  );

  // R1: nothing is offered in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> !out_valid);

endmodule

// File: tb/sim_bg_stream_gen.sv
module sim_bg_stream_gen;

  localparam int DAT_W  = 16;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 16;
  localparam int REG_W  = 32;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst = 1'b1;
  logic               reg_wr = 1'b0;
  logic [2:0]         reg_addr = '0;
  logic [REG_W-1:0]   reg_wdata = '0;
  logic               buf_wr = 1'b0;
  logic [ADDR_W-1:0]  buf_addr = '0;
  logic [2*DAT_W-1:0] buf_wdata = '0;
  logic               out_ready = 1'b1;
  logic               out_valid, out_sop, out_eop, out_sync;
  logic [DAT_W-1:0]   out_re, out_im;
  logic [2*REG_W-1:0] out_bsn;

  bg_stream_gen #(
    .DAT_W(DAT_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .out_ready(out_ready),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync),
    .out_re(out_re), .out_im(out_im), .out_bsn(out_bsn)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [2*DAT_W-1:0] mirror [DEPTH];

  int unsigned m_len, m_bps, m_gap, m_start, m_end;
  logic [63:0] m_init;
  int unsigned n_acc;
  bit  gap_chk, seen_eop, last_was_eop, mon_en, rand_ready;
  int  idle_cnt;
  bit  prev_stall;
  logic [99:0] prev_snap;

  function automatic void check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  function automatic int unsigned eff(int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // Reference beat model evaluated on each accepted beat
  always @(negedge clk) begin
    if (mon_en) begin
      automatic logic [99:0] cur = {out_valid, out_sop, out_eop, out_sync, out_re, out_im, out_bsn};
      if (prev_stall)
        check(cur == prev_snap, "R8", "stalled beat changed", out_bsn, prev_snap[63:0]);
      if (out_valid && out_ready) begin
        automatic int unsigned le = eff(m_len);
        automatic int unsigned be = eff(m_bps);
        automatic int unsigned w  = m_end - m_start + 1;
        automatic int unsigned ad = m_start + (n_acc % w);
        automatic int unsigned bk = n_acc / le;
        automatic int unsigned ps = n_acc % le;
        automatic logic [2*DAT_W-1:0] ew = mirror[ad];
        check(out_re == ew[DAT_W-1:0], "R10", "re sample/address", out_re, ew[DAT_W-1:0]);
        check(out_im == ew[2*DAT_W-1:DAT_W], "R3", "im packing", out_im, ew[2*DAT_W-1:DAT_W]);
        check(out_sop == (ps == 0), "R4", "sop position", out_sop, ps == 0);
        check(out_eop == (ps == le - 1), "R4", "eop position", out_eop, ps == le - 1);
        check(out_sync == ((ps == 0) && (bk % be == 0)), "R6", "sync", out_sync, (ps == 0) && (bk % be == 0));
        check(out_bsn == m_init + 64'(bk), "R7", "sequence number", out_bsn, m_init + 64'(bk));
        if (ps == 0 && gap_chk && seen_eop)
          check(idle_cnt == int'(m_gap), "R5", "gap cycles", idle_cnt, m_gap);
        if (out_eop) begin
          seen_eop = 1;
          idle_cnt = 0;
        end
        last_was_eop = out_eop;
        n_acc++;
      end else if (!out_valid) begin
        idle_cnt++;
      end
      prev_stall = out_valid && !out_ready;
      prev_snap  = cur;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = rand_ready ? (($urandom % 100) < 65) : 1'b1;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic buf_write(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    buf_wr = 1'b1; buf_addr = ADDR_W'(a); buf_wdata = d;
    mirror[a] = d;
    @(posedge clk); #1;
    buf_wr = 1'b0;
  endtask

  task automatic run(input int unsigned len, input int unsigned bps, input int unsigned gap,
                     input int unsigned st, input int unsigned en, input logic [63:0] init,
                     input int unsigned nbeats, input bit rr, input bit gc);
    int t;
    m_len = len; m_bps = bps; m_gap = gap; m_start = st; m_end = en; m_init = init;
    n_acc = 0; seen_eop = 0; idle_cnt = 0; last_was_eop = 0; gap_chk = gc; rand_ready = rr;
    reg_write(3'd1, len);
    reg_write(3'd2, bps);
    reg_write(3'd3, gap);
    reg_write(3'd4, st);
    reg_write(3'd5, en);
    reg_write(3'd6, init[31:0]);
    reg_write(3'd7, init[63:32]);
    reg_write(3'd0, 32'd1);
    t = 0;
    while (n_acc < nbeats && t < 20000) begin
      @(posedge clk);
      t++;
    end
    check(t < 20000, "R4", "beats not produced", n_acc, nbeats);
    reg_write(3'd0, 32'd0);
    repeat (300) @(posedge clk);
    rand_ready = 0;
    repeat (60) @(posedge clk);
    @(negedge clk);
    check(n_acc % eff(len) == 0, "R9", "block cut short", n_acc % eff(len), 0);
    check(last_was_eop, "R9", "last beat not eop", last_was_eop, 1);
    check(!out_valid, "R9", "valid after stop", out_valid, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    mon_en = 0; rand_ready = 0; prev_stall = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !out_sop && !out_eop && !out_sync, "R1", "reset outputs",
          {out_valid, out_sop, out_eop, out_sync}, 0);
    // R1: nothing comes out while disabled
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1", "idle after reset", out_valid, 0);

    for (int i = 0; i < DEPTH; i++) buf_write(i, $urandom);
    mon_en = 1;

    // Directed: gaps, sync period 3, mid-block stop (R5, R6, R9)
    run(4, 3, 2, 0, 7, 64'd32, 42, 0, 1);
    // Directed: window at top of buffer, carry into upper half, back-pressure (R7, R8, R10)
    run(5, 2, 0, 58, 63, 64'h0000_0001_FFFF_FFFE, 37, 1, 0);
    // Directed: zero length and zero sync count act as 1, one-entry window (R2, R5)
    run(0, 0, 1, 5, 5, 64'd0, 9, 0, 1);
    // Directed: window shorter than a block, longer gap (R5, R10)
    run(7, 1, 3, 20, 22, 64'd100, 15, 0, 1);
    // Directed: back-to-back blocks with ready held high (R5)
    run(3, 4, 0, 30, 40, 64'hFFFF_FFFF_FFFF_FFFD, 20, 0, 1);

    for (int k = 0; k < 6; k++) begin
      automatic int unsigned l  = 1 + $urandom % 12;
      automatic int unsigned b  = 1 + $urandom % 5;
      automatic int unsigned g  = $urandom % 5;
      automatic int unsigned s  = $urandom % 41;
      automatic int unsigned e  = s + $urandom % 21;
      automatic logic [63:0] in = {$urandom, $urandom};
      automatic int unsigned nb = 10 + $urandom % 51;
      run(l, b, g, s, e, in, nb, 1, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule